// File: doc/BRIEF.md
# Serial Host Interrupt and Error Status Aggregator

This block gathers the error and event conditions of a serial host controller and turns them into two level interrupt lines, one for errors and one for events. The FIFO and command logic feed it single-cycle error pulses and level status flags. Software reaches its registers through a word-addressed port: write enable, address and write data, with combinational read data.

An interrupt line is gated twice. First, a per-cause mask selects which error causes or status flags may raise the line. Second, a per-line enable decides whether the line may latch a pending bit and drive its output at all. Error causes are sticky until software writes a one to clear them. A force register pulses either line for one cycle. This lets software exercise the interrupt path without a real fault.

Status flags are edge-detected. A flag that stays set latches its event only once. After software clears the pending bit, the flag must fall and rise again before the event latches a second time.

Top module: `shost_irq_agg`

Register map, by word address:

| Address | Register | Contents |
|---|---|---|
| 0 | pending | write-one-to-clear |
| 1 | line enable | read/write |
| 2 | force | write-only, reads 0 |
| 3 | cause mask | bits 4:0 |
| 4 | cause | write-one-to-clear |
| 5 | event mask | bits 5:0 |
| 6 | live flags | read-only |

## Requirements
- R1: After reset the cause mask (word 3) reads 0x1F, the event mask (word 5), pending (word 0) and cause (word 4) read 0, and both interrupt outputs are low.
- R2: Cause bit i (word 4) becomes set one cycle after a pulse on `err_pulse[i]` and stays set. The bit order from bit 0 is: command while busy, overflow, underflow, bad command, bad chip-select id, bad access.
- R3: Cause and pending are write-one-to-clear. A written 0 leaves a bit unchanged. If a set condition and a clear arrive in the same cycle, the set wins.
- R4: Pending bit 0 (error) latches one cycle after any cause bit in 4:0 is set while the matching cause-mask bit (word 3, bits 4:0) is 1. Cause bit 5 has no mask bit and never raises the error line.
- R5: A pending bit never latches while its line-enable bit is 0. Line enable is word 1, with bit 0 for errors and bit 1 for events.
- R6: Event-mask bits 0 (RX full), 1 (TX empty) and 4 (ready) latch pending bit 1 on a rising edge of the matching bit of `stat_flags`. A flag that stays high latches only once.
- R7: Event-mask bits 2 (RX watermark), 3 (TX watermark) and 5 (idle) are stored and read back, but they never raise the event line.
- R8: Writing a 1 to force bit 0 or bit 1 (word 2) drives that line high for the following cycle only. If the line is enabled, it also latches that pending bit. A force that arrives while its line is disabled leaves no trace.
- R9: `irq_err_o` equals (pending[0] OR force[0]) AND enable[0], and `irq_evt_o` is the same for bit 1. Disabling a line drops its output while its pending bit stays set.
- R10: The line enable reads back its written value, and word 6 returns the live `stat_flags`.
- R11: Word 7 reads 0, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| err_pulse | input | 6 | Single-cycle error cause pulses |
| stat_flags | input | 6 | Live status flags, same order as the event mask |
| irq_err_o | output | 1 | Error interrupt line |
| irq_evt_o | output | 1 | Event interrupt line |

## Verification
The bench builds the block with its default parameters: six causes, of which five are maskable, six event flags, and the live-event pattern 0b010011. With these values every cause position is within reach, including the unmaskable sixth. So are the three event flags that can fire, the three that cannot, and word 7, which is the only unmapped word at this address width. The default parameters also expose the same-cycle set-versus-clear race on the pending bit, and the difference between a held flag and a re-rising one.

// File: rtl/shost_irq_pkg.sv
// Shared register indices and line numbering for the interrupt aggregator.
package shost_irq_pkg;
    localparam int REG_AW  = 3;
    localparam int N_LINES = 2;
    localparam int LINE_ERR = 0;
    localparam int LINE_EVT = 1;

    typedef enum logic [REG_AW-1:0] {
        RA_PEND  = 3'd0,
        RA_IEN   = 3'd1,
        RA_FORCE = 3'd2,
        RA_CMASK = 3'd3,
        RA_CAUSE = 3'd4,
        RA_EMASK = 3'd5,
        RA_FLAGS = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/shost_err_capture.sv
// Sticky error-cause capture with a maskable subset.
// Assumes: N_MASKABLE <= N_CAUSE; causes above N_MASKABLE-1 have no mask bit
// and never contribute to err_hit. A pulse beats a clear in the same cycle.
module shost_err_capture #(
    parameter int N_CAUSE    = 6,
    parameter int N_MASKABLE = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CAUSE-1:0]    err_pulse,
    input  logic                  clr_we,
    input  logic [N_CAUSE-1:0]    clr_bits,
    input  logic                  mask_we,
    input  logic [N_MASKABLE-1:0] mask_wbits,
    output logic [N_CAUSE-1:0]    cause_q,
    output logic [N_MASKABLE-1:0] mask_q,
    output logic                  err_hit
);
    genvar i;
    generate
        for (i = 0; i < N_CAUSE; i++) begin : g_cause
            // Hold one cause bit: set on its pulse, clear on write-one
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cause_q[i] <= 1'b0;
                else if (err_pulse[i])
                    cause_q[i] <= 1'b1;
                else if (clr_we && clr_bits[i])
                    cause_q[i] <= 1'b0;
            end

            assert_cause_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                err_pulse[i] |=> cause_q[i]);
            assert_cause_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cause_q[i] && !(clr_we && clr_bits[i])) |=> cause_q[i]);
        end
    endgenerate

    // Cause mask register, all causes enabled out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= {N_MASKABLE{1'b1}};
        else if (mask_we)
            mask_q <= mask_wbits;
    end

    // Any enabled, recorded cause requests the error line
    always_comb err_hit = |(cause_q[N_MASKABLE-1:0] & mask_q);
endmodule

// File: rtl/shost_evt_detect.sv
// Rising-edge event detection on live status flags.
// Assumes: EVT_LIVE marks the flags allowed to raise events; other mask bits
// are storage only. Flags are synchronous to clk.
module shost_evt_detect #(
    parameter int               N_EVT    = 6,
    parameter logic [N_EVT-1:0] EVT_LIVE = 6'b010011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] flags,
    input  logic             mask_we,
    input  logic [N_EVT-1:0] mask_wbits,
    output logic [N_EVT-1:0] mask_q,
    output logic             evt_hit
);
    logic [N_EVT-1:0] flags_q;
    logic [N_EVT-1:0] rise;

    // Remember last cycle's flags for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags;
    end

    // Event mask register, cleared at reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_wbits;
    end

    // Newly risen, enabled and live flags form an event
    always_comb begin
        rise    = flags & ~flags_q;
        evt_hit = |(rise & mask_q & EVT_LIVE);
    end

    assert_held_flag_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == flags_q) |-> !evt_hit);
endmodule

// File: rtl/shost_irq_line.sv
// One interrupt line: pending latch plus output gating.
// Assumes: force_q is a one-cycle strobe; clr is the write-one-to-clear
// strobe for this line's pending bit. A set beats a clear.
module shost_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic force_q,
    input  logic hit,
    input  logic clr,
    output logic pend_q,
    output logic irq
);
    // Latch the pending bit while the line is enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (en && (force_q || hit))
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end

    // Drive the level output from pending or force, gated by enable
    always_comb irq = (pend_q | force_q) & en;

    assert_no_latch_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pend_q) |=> !pend_q);
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (force_q || hit)) |=> pend_q);
endmodule

// File: rtl/shost_irq_agg.sv
// Interrupt and error status aggregator for a serial host controller.
// Holds line enable and force registers, decodes the register port, and
// combines the cause-capture, event-detect and two line instances.
// Assumes: single-cycle err_pulse strobes, synchronous stat_flags, and
// N_MASKABLE <= N_CAUSE <= DATA_W, N_EVT <= DATA_W.
module shost_irq_agg
    import shost_irq_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               N_CAUSE    = 6,
    parameter int               N_MASKABLE = 5,
    parameter int               N_EVT      = 6,
    parameter logic [N_EVT-1:0] EVT_LIVE   = 6'b010011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CAUSE-1:0] err_pulse,
    input  logic [N_EVT-1:0]  stat_flags,
    output logic              irq_err_o,
    output logic              irq_evt_o
);
    reg_addr_e              addr_e;
    logic                   wr_pend, wr_ien, wr_force, wr_cmask, wr_cause, wr_emask;
    logic [N_LINES-1:0]     ien_q;
    logic [N_LINES-1:0]     force_q;
    logic [N_LINES-1:0]     pend_q;
    logic [N_LINES-1:0]     line_hit;
    logic [N_LINES-1:0]     line_irq;
    logic [N_CAUSE-1:0]     cause_q;
    logic [N_MASKABLE-1:0]  cmask_q;
    logic [N_EVT-1:0]       emask_q;
    logic                   err_hit;
    logic                   evt_hit;

    // Decode the write strobe per register
    always_comb begin
        addr_e   = reg_addr_e'(bus_addr);
        wr_pend  = bus_we && (addr_e == RA_PEND);
        wr_ien   = bus_we && (addr_e == RA_IEN);
        wr_force = bus_we && (addr_e == RA_FORCE);
        wr_cmask = bus_we && (addr_e == RA_CMASK);
        wr_cause = bus_we && (addr_e == RA_CAUSE);
        wr_emask = bus_we && (addr_e == RA_EMASK);
    end

    // Line enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (wr_ien)
            ien_q <= bus_wdata[N_LINES-1:0];
    end

    // Force strobes live for one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_q <= '0;
        else if (wr_force)
            force_q <= bus_wdata[N_LINES-1:0];
        else
            force_q <= '0;
    end

    shost_err_capture #(
        .N_CAUSE    (N_CAUSE),
        .N_MASKABLE (N_MASKABLE)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_pulse  (err_pulse),
        .clr_we     (wr_cause),
        .clr_bits   (bus_wdata[N_CAUSE-1:0]),
        .mask_we    (wr_cmask),
        .mask_wbits (bus_wdata[N_MASKABLE-1:0]),
        .cause_q    (cause_q),
        .mask_q     (cmask_q),
        .err_hit    (err_hit)
    );

    shost_evt_detect #(
        .N_EVT      (N_EVT),
        .EVT_LIVE   (EVT_LIVE)
    ) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags      (stat_flags),
        .mask_we    (wr_emask),
        .mask_wbits (bus_wdata[N_EVT-1:0]),
        .mask_q     (emask_q),
        .evt_hit    (evt_hit)
    );

    // Route each source to its line
    always_comb begin
        line_hit           = '0;
        line_hit[LINE_ERR] = err_hit;
        line_hit[LINE_EVT] = evt_hit;
    end

    genvar l;
    generate
        for (l = 0; l < N_LINES; l++) begin : g_line
            shost_irq_line u_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (ien_q[l]),
                .force_q (force_q[l]),
                .hit     (line_hit[l]),
                .clr     (wr_pend && bus_wdata[l]),
                .pend_q  (pend_q[l]),
                .irq     (line_irq[l])
            );
        end
    endgenerate

    always_comb begin
        irq_err_o = line_irq[LINE_ERR];
        irq_evt_o = line_irq[LINE_EVT];
    end

    // Register read multiplexer; force and unmapped words read zero
    always_comb begin
        case (addr_e)
            RA_PEND:  bus_rdata = DATA_W'(pend_q);
            RA_IEN:   bus_rdata = DATA_W'(ien_q);
            RA_CMASK: bus_rdata = DATA_W'(cmask_q);
            RA_CAUSE: bus_rdata = DATA_W'(cause_q);
            RA_EMASK: bus_rdata = DATA_W'(emask_q);
            RA_FLAGS: bus_rdata = DATA_W'(stat_flags);
            default:  bus_rdata = '0;
        endcase
    end

    assert_force_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_force |=> (force_q == '0));
    assert_line_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q[LINE_ERR] |-> !irq_err_o);
endmodule

// File: tb/shost_irq_agg_bench.sv
module shost_irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  err_pulse = '0;
    logic [5:0]  stat_flags = '0;
    logic        irq_err_o, irq_evt_o;

    typedef struct {
        bit          pins;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t it;
    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] act;

    always #10 clk = ~clk;

    shost_irq_agg u_shost_irq_agg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .err_pulse  (err_pulse),
        .stat_flags (stat_flags),
        .irq_err_o  (irq_err_o),
        .irq_evt_o  (irq_evt_o)
    );

    // Monitor: pop one expected item per cycle and compare mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            it  = q.pop_front();
            act = it.pins ? {30'b0, irq_evt_o, irq_err_o} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] p);
        err_pulse = p;
        @(posedge clk); #1;
        err_pulse = '0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t x;
        bus_addr = a;
        x.pins = 1'b0; x.exp = e; x.tag = tag;
        q.push_back(x);
        @(posedge clk); #1;
    endtask

    task automatic chk_pins(input logic [1:0] e, input string tag);
        item_t x;
        x.pins = 1'b1; x.exp = {30'b0, e}; x.tag = tag;
        q.push_back(x);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_reg(3'd3, 32'h1F, "R1");
        chk_reg(3'd5, 32'h0,  "R1");
        chk_reg(3'd0, 32'h0,  "R1");
        chk_reg(3'd4, 32'h0,  "R1");
        chk_pins(2'b00, "R1");
        // R2 sticky cause; R5 no latch while disabled
        pulse(6'h02);
        idle(2);
        chk_reg(3'd4, 32'h02, "R2");
        chk_reg(3'd0, 32'h0,  "R5");
        chk_pins(2'b00, "R5");
        // R3 write zero keeps, write one clears
        wr(3'd4, 32'h0);
        chk_reg(3'd4, 32'h02, "R3");
        wr(3'd4, 32'h02);
        chk_reg(3'd4, 32'h0,  "R3");
        // R4 masked cause latches error pending
        wr(3'd1, 32'h1);
        pulse(6'h08);
        idle(1);
        chk_reg(3'd0, 32'h1, "R4");
        chk_pins(2'b01, "R4");
        wr(3'd0, 32'h1);
        chk_reg(3'd0, 32'h1, "R3");
        wr(3'd4, 32'h08);
        wr(3'd0, 32'h1);
        chk_reg(3'd0, 32'h0, "R3");
        chk_pins(2'b00, "R3");
        // R4 unmaskable cause 5 and a masked-off cause
        pulse(6'h20);
        idle(2);
        chk_reg(3'd4, 32'h20, "R2");
        chk_reg(3'd0, 32'h0,  "R4");
        wr(3'd4, 32'h20);
        wr(3'd3, 32'h1E);
        pulse(6'h01);
        idle(2);
        chk_reg(3'd0, 32'h0,  "R4");
        chk_reg(3'd4, 32'h01, "R2");
        wr(3'd4, 32'h01);
        wr(3'd3, 32'h1F);
        // R6 event on rising ready flag, once while held
        wr(3'd1, 32'h2);
        wr(3'd5, 32'h10);
        stat_flags = 6'h10;
        idle(1);
        chk_reg(3'd0, 32'h2, "R6");
        chk_pins(2'b10, "R6");
        chk_reg(3'd6, 32'h10, "R10");
        wr(3'd0, 32'h2);
        idle(2);
        chk_reg(3'd0, 32'h0, "R6");
        stat_flags = 6'h00;
        idle(1);
        stat_flags = 6'h10;
        idle(1);
        chk_reg(3'd0, 32'h2, "R6");
        wr(3'd0, 32'h2);
        stat_flags = 6'h00;
        wr(3'd5, 32'h02);
        stat_flags = 6'h02;
        idle(1);
        chk_reg(3'd0, 32'h2, "R6");
        wr(3'd0, 32'h2);
        stat_flags = 6'h00;
        // R7 watermark and idle flags are inert
        wr(3'd5, 32'h2C);
        stat_flags = 6'h2C;
        idle(2);
        chk_reg(3'd0, 32'h0, "R7");
        chk_pins(2'b00, "R7");
        chk_reg(3'd5, 32'h2C, "R7");
        stat_flags = 6'h00;
        // R8 force while disabled leaves no trace
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h2);
        chk_pins(2'b00, "R8");
        wr(3'd1, 32'h2);
        chk_pins(2'b00, "R8");
        chk_reg(3'd0, 32'h0, "R8");
        // R8 force with line enabled, R9 gating
        wr(3'd1, 32'h1);
        wr(3'd2, 32'h1);
        chk_pins(2'b01, "R8");
        chk_reg(3'd0, 32'h1, "R8");
        chk_reg(3'd2, 32'h0, "R8");
        wr(3'd1, 32'h0);
        chk_pins(2'b00, "R9");
        chk_reg(3'd0, 32'h1, "R9");
        wr(3'd1, 32'h1);
        chk_pins(2'b01, "R9");
        wr(3'd0, 32'h1);
        chk_pins(2'b00, "R9");
        // R10 enable readback; R11 unmapped word
        wr(3'd1, 32'h3);
        chk_reg(3'd1, 32'h3, "R10");
        chk_reg(3'd7, 32'h0, "R11");
        wr(3'd7, 32'hFFFF_FFFF);
        chk_reg(3'd3, 32'h1F, "R11");
        chk_reg(3'd5, 32'h2C, "R11");
        chk_reg(3'd1, 32'h3,  "R11");
        chk_reg(3'd0, 32'h0,  "R11");
        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule